// File: doc/BRIEF.md
# DMA Byte-Port SDRAM Bridge

This bridge links an external DMA engine with a byte-wide data path to an SDRAM controller that moves 64-bit words. Software first loads a word start address. It then writes a 2-bit transfer mode into a small control register. The mode is idle, read, write or block move. The bridge tells the DMA engine when it may move another byte by driving an active-low request line, `dreq_n`.

In read mode the bridge fetches whole words from SDRAM. The address steps up by one word after each accepted request. Fetched words go into a private 8-entry FIFO, and the DMA engine takes them out one byte at a time, least significant byte first. In write mode the bridge collects bytes from the DMA engine, packs every eight into one word in the same little-endian order, queues the word in an 8-entry FIFO and sends it to SDRAM at the next word address.

Both byte ports and both SDRAM request channels are valid/ready streams. A transfer happens on a rising clock edge where both valid and ready are high. While valid is high and ready is low, the sender holds its data and address steady. The SDRAM read-return channel has no ready signal. The bridge caps the number of outstanding requests so that every word that comes back always has room in the FIFO. Writing the idle mode empties both FIFOs and throws away any partly packed word.

Top module: `dma_byte_bridge`

## Requirements
- R1: After reset the mode is idle, `dreq_n` is 1, and `rb_valid`, `wb_ready`, `sd_rd_req_valid` and `sd_wr_valid` are all 0.
- R2: In idle mode (00) and in block-move mode (11), `dreq_n` stays 1, no SDRAM read request is made, `wb_ready` is 0 and `rb_valid` is 0.
- R3: In read mode (01), read requests carry consecutive word addresses. The first request uses the loaded start address, and each accepted request adds one.
- R4: In read mode, a new request is offered only while the words already in the read FIFO plus the requests still waiting for data number fewer than 6.
- R5: The read byte port gives out the 8 bytes of each fetched word with byte k taken from bits [8k+7:8k], and gives out the words in the order of their addresses.
- R6: In read mode, `dreq_n` is 0 exactly when at least one unread byte is held in the read FIFO, and 1 when the FIFO is empty.
- R7: In write mode (10), each group of 8 accepted bytes becomes one 64-bit word with the k-th byte in bits [8k+7:8k]. The words go out to SDRAM at the start address, then the start address plus 1, and so on.
- R8: In write mode, `dreq_n` is 0 while the write FIFO holds fewer than 6 words and 1 from 6 words upward. `wb_ready` is 0 while the write FIFO holds 8 words.
- R9: Writing the idle mode empties both FIFOs and discards a partly packed word, so the first word after write mode is entered again holds only bytes accepted after that point.
- R10: Control register bit 0 is reserved and has no effect. The mode is taken from bits [2:1] only.
- R11: While `sd_wr_valid` is high and `sd_wr_ready` is low, `sd_wr_data` and `sd_wr_addr` hold steady. While `rb_valid` is high and `rb_ready` is low, `rb_data` holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control value; bits [2:1] are the mode, bit 0 is reserved |
| addr_we | input | 1 | Start address load strobe |
| addr_wdata | input | AW | Start word address |
| dreq_n | output | 1 | Active-low transfer request to the DMA engine |
| wb_valid | input | 1 | Write byte valid |
| wb_data | input | 8 | Write byte |
| wb_ready | output | 1 | Write byte accepted |
| rb_valid | output | 1 | Read byte valid |
| rb_data | output | 8 | Read byte |
| rb_ready | input | 1 | Read byte taken |
| sd_rd_req_valid | output | 1 | SDRAM read request valid |
| sd_rd_req_ready | input | 1 | SDRAM read request accepted |
| sd_rd_addr | output | AW | SDRAM read word address |
| sd_rd_data_valid | input | 1 | SDRAM read data return |
| sd_rd_data | input | 64 | SDRAM read word |
| sd_wr_valid | output | 1 | SDRAM write valid |
| sd_wr_ready | input | 1 | SDRAM write accepted |
| sd_wr_addr | output | AW | SDRAM write word address |
| sd_wr_data | output | 64 | SDRAM write word |

## Verification
The assertions assume three things about the inputs. The SDRAM side returns exactly one data word for each accepted read request, and returns the words in request order. The start address is not reloaded while a request is waiting for acceptance. The mode is not changed while a byte or word handshake is pending. The bench's SDRAM model answers each accepted request one cycle later and never answers without a request. Address loads and mode writes are made only while the DMA engine is quiet and after the bench has waited for the queues to settle.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
  typedef enum logic [1:0] {
    M_IDLE  = 2'b00,
    M_READ  = 2'b01,
    M_WRITE = 2'b10,
    M_MOVE  = 2'b11
  } dbb_mode_e;
endpackage

// File: rtl/dbb_fifo.sv
module dbb_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr] <= din;
  end
endmodule

// File: rtl/dbb_unpack.sv
module dbb_unpack #(
  parameter int BW = 8,
  parameter int NB = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic [BW*NB-1:0] word,
  input  logic           take,
  output logic [BW-1:0]  lane,
  output logic           last
);
  localparam int IW = $clog2(NB);
  logic [IW-1:0] idx;

  assign lane = word[idx*BW +: BW];
  assign last = take && (idx == IW'(NB - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (flush) idx <= '0;
    else if (take)  idx <= last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/dbb_pack.sv
module dbb_pack #(
  parameter int BW = 8,
  parameter int NB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [BW-1:0]    lane,
  input  logic             take,
  output logic [BW*NB-1:0] word,
  output logic             done
);
  localparam int IW = $clog2(NB);
  logic [IW-1:0]    idx;
  logic [BW*NB-1:0] acc;

  assign done = take && (idx == IW'(NB - 1));

  always_comb begin
    word = acc;
    word[(NB-1)*BW +: BW] = lane;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      acc <= '0;
    end else if (flush) begin
      idx <= '0;
    end else if (take) begin
      acc[idx*BW +: BW] <= lane;
      idx <= done ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/dma_byte_bridge.sv
module dma_byte_bridge #(
  parameter int AW        = 24,
  parameter int BW        = 8,
  parameter int NB        = 8,
  parameter int DEPTH     = 8,
  parameter int NEAR_FULL = 6,
  localparam int DW = BW * NB,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  input  logic          addr_we,
  input  logic [AW-1:0] addr_wdata,
  output logic          dreq_n,
  input  logic          wb_valid,
  input  logic [BW-1:0] wb_data,
  output logic          wb_ready,
  output logic          rb_valid,
  output logic [BW-1:0] rb_data,
  input  logic          rb_ready,
  output logic          sd_rd_req_valid,
  input  logic          sd_rd_req_ready,
  output logic [AW-1:0] sd_rd_addr,
  input  logic          sd_rd_data_valid,
  input  logic [DW-1:0] sd_rd_data,
  output logic          sd_wr_valid,
  input  logic          sd_wr_ready,
  output logic [AW-1:0] sd_wr_addr,
  output logic [DW-1:0] sd_wr_data
);
  import dbb_pkg::*;

  dbb_mode_e     mode_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] pend_q, rd_cnt, wr_cnt;
  logic          flush, rd_mode, wr_mode;
  logic          rd_hs, wr_hs, rb_take, rb_last, wb_take, wb_done;
  logic [DW-1:0] rd_head, pk_word;
  logic [CW:0]   credit;

  assign flush   = cfg_we && (dbb_mode_e'(cfg_wdata[2:1]) == M_IDLE);
  assign rd_mode = (mode_q == M_READ);
  assign wr_mode = (mode_q == M_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= M_IDLE;
    else if (cfg_we) mode_q <= dbb_mode_e'(cfg_wdata[2:1]);
  end

  // Word address shared by both directions.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             addr_q <= '0;
    else if (addr_we)       addr_q <= addr_wdata;
    else if (rd_hs || wr_hs) addr_q <= addr_q + 1'b1;
  end

  // Read path: requests still waiting for their data word.
  assign credit          = {1'b0, rd_cnt} + {1'b0, pend_q};
  assign sd_rd_req_valid = rd_mode && (credit < (CW+1)'(NEAR_FULL));
  assign sd_rd_addr      = addr_q;
  assign rd_hs           = sd_rd_req_valid && sd_rd_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (rd_hs && !sd_rd_data_valid) pend_q <= pend_q + 1'b1;
    else if (!rd_hs && sd_rd_data_valid && pend_q != '0) pend_q <= pend_q - 1'b1;
  end

  dbb_fifo #(.W(DW), .DEPTH(DEPTH)) u_rd_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(sd_rd_data_valid && rd_mode && !flush), .din(sd_rd_data),
    .pop(rb_last), .dout(rd_head), .count(rd_cnt)
  );

  assign rb_valid = rd_mode && (rd_cnt != '0);
  assign rb_take  = rb_valid && rb_ready;

  dbb_unpack #(.BW(BW), .NB(NB)) u_unpack (
    .clk(clk), .rst_n(rst_n), .flush(flush), .word(rd_head),
    .take(rb_take), .lane(rb_data), .last(rb_last)
  );

  // Write path.
  assign wb_ready = wr_mode && (wr_cnt != CW'(DEPTH));
  assign wb_take  = wb_valid && wb_ready;

  dbb_pack #(.BW(BW), .NB(NB)) u_pack (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lane(wb_data),
    .take(wb_take), .word(pk_word), .done(wb_done)
  );

  dbb_fifo #(.W(DW), .DEPTH(DEPTH)) u_wr_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(wb_done), .din(pk_word),
    .pop(wr_hs), .dout(sd_wr_data), .count(wr_cnt)
  );

  assign sd_wr_valid = wr_mode && (wr_cnt != '0);
  assign sd_wr_addr  = addr_q;
  assign wr_hs       = sd_wr_valid && sd_wr_ready;

  always_comb begin
    unique case (mode_q)
      M_READ:  dreq_n = (rd_cnt == '0);
      M_WRITE: dreq_n = (wr_cnt >= CW'(NEAR_FULL));
      default: dreq_n = 1'b1;
    endcase
  end
endmodule

// File: rtl/dbb_checker.sv
module dbb_checker #(
  parameter int AW        = 24,
  parameter int BW        = 8,
  parameter int DW        = 64,
  parameter int DEPTH     = 8,
  parameter int NEAR_FULL = 6,
  parameter int CW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic [CW-1:0] rcnt,
  input logic [CW-1:0] wcnt,
  input logic [CW-1:0] pend,
  input logic          cfg_we,
  input logic          addr_we,
  input logic          dreq_n,
  input logic          wb_ready,
  input logic          rb_valid,
  input logic          rb_ready,
  input logic [BW-1:0] rb_data,
  input logic          sd_rd_req_valid,
  input logic          sd_rd_req_ready,
  input logic [AW-1:0] sd_rd_addr,
  input logic          sd_wr_valid,
  input logic          sd_wr_ready,
  input logic [AW-1:0] sd_wr_addr,
  input logic [DW-1:0] sd_wr_data
);
  p_quiet_modes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |-> (dreq_n && !sd_rd_req_valid && !wb_ready && !rb_valid));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_rd_req_valid && sd_rd_req_ready && !addr_we && !cfg_we) |=>
      (!sd_rd_req_valid || sd_rd_addr == $past(sd_rd_addr) + 1'b1));

  p_fill_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rcnt} + {1'b0, pend}) <= (CW+1)'(NEAR_FULL));

  p_dreq_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (dreq_n == !rb_valid));

  p_wr_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt == CW'(DEPTH)) |-> (!wb_ready && dreq_n));

  p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_wr_valid && !sd_wr_ready && !cfg_we && !addr_we) |=>
      (sd_wr_valid && $stable(sd_wr_data) && $stable(sd_wr_addr)));

  p_rb_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_valid && !rb_ready && !cfg_we) |=> (rb_valid && $stable(rb_data)));
endmodule

bind dma_byte_bridge dbb_checker #(
  .AW(AW), .BW(BW), .DW(DW), .DEPTH(DEPTH), .NEAR_FULL(NEAR_FULL), .CW(CW)
) u_dbb_checker (
  .clk(clk), .rst_n(rst_n), .mode(mode_q), .rcnt(rd_cnt), .wcnt(wr_cnt),
  .pend(pend_q), .cfg_we(cfg_we), .addr_we(addr_we), .dreq_n(dreq_n),
  .wb_ready(wb_ready), .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_data(rb_data),
  .sd_rd_req_valid(sd_rd_req_valid), .sd_rd_req_ready(sd_rd_req_ready),
  .sd_rd_addr(sd_rd_addr), .sd_wr_valid(sd_wr_valid), .sd_wr_ready(sd_wr_ready),
  .sd_wr_addr(sd_wr_addr), .sd_wr_data(sd_wr_data)
);

// File: tb/dma_byte_bridge_test.sv
`timescale 1ns/1ps
module dma_byte_bridge_test;
  localparam int AW = 24;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cfg_we = 0;
  logic [7:0]    cfg_wdata = 0;
  logic          addr_we = 0;
  logic [AW-1:0] addr_wdata = 0;
  logic          dreq_n;
  logic          wb_valid = 0;
  logic [7:0]    wb_data = 0;
  logic          wb_ready;
  logic          rb_valid;
  logic [7:0]    rb_data;
  logic          rb_ready = 0;
  logic          sd_rd_req_valid;
  logic          sd_rd_req_ready = 0;
  logic [AW-1:0] sd_rd_addr;
  logic          sd_rd_data_valid = 0;
  logic [63:0]   sd_rd_data = 0;
  logic          sd_wr_valid;
  logic          sd_wr_ready = 0;
  logic [AW-1:0] sd_wr_addr;
  logic [63:0]   sd_wr_data;

  dma_byte_bridge uut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit rd_stall = 0, wr_stall = 1;
  int rd_reqs = 0, cyc = 0;
  logic [AW-1:0] exp_rd_addr = 0;
  logic [AW-1:0] rsp_q[$];
  logic [63:0]   wq_data[$];
  logic [AW-1:0] wq_addr[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_byte(input logic [AW-1:0] a, input int k);
    return 8'((int'(a) * 8 + k) * 5 + 1);
  endfunction

  function automatic logic [63:0] rd_word(input logic [AW-1:0] a);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[k*8 +: 8] = rd_byte(a, k);
    return w;
  endfunction

  function automatic logic [7:0] wr_byte(input int i);
    return 8'(i * 7 + 3);
  endfunction

  // SDRAM model, driven away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      sd_rd_data_valid = 0;
      if (rsp_q.size() > 0) begin
        sd_rd_data = rd_word(rsp_q.pop_front());
        sd_rd_data_valid = 1;
      end
      sd_rd_req_ready = !rd_stall && (cyc % 3 != 1);
      if (rst_n && sd_rd_req_valid && sd_rd_req_ready) begin
        chk(sd_rd_addr == exp_rd_addr, "R3 read address", 64'(sd_rd_addr), 64'(exp_rd_addr));
        exp_rd_addr = exp_rd_addr + 1;
        rsp_q.push_back(sd_rd_addr);
        rd_reqs++;
      end
      sd_wr_ready = !wr_stall && (cyc % 2 == 0);
      if (rst_n && sd_wr_valid && sd_wr_ready) begin
        wq_data.push_back(sd_wr_data);
        wq_addr.push_back(sd_wr_addr);
      end
      cyc++;
    end
  end

  task automatic set_cfg(input logic [7:0] v);
    cfg_wdata = v; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic load_addr(input logic [AW-1:0] a);
    addr_wdata = a; addr_we = 1;
    @(negedge clk);
    addr_we = 0;
  endtask

  task automatic get_byte(output logic [7:0] b);
    while (!rb_valid) @(negedge clk);
    b = rb_data;
    rb_ready = 1;
    @(negedge clk);
    rb_ready = 0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    wb_data = b; wb_valid = 1;
    while (!wb_ready) @(negedge clk);
    @(negedge clk);
    wb_valid = 0;
  endtask

  task automatic quiet_checks(input string req);
    int snap;
    repeat (3) @(negedge clk);
    snap = rd_reqs;
    repeat (10) @(negedge clk);
    chk(rd_reqs == snap, req, 64'(rd_reqs), 64'(snap));
    chk(dreq_n == 1, req, 64'(dreq_n), 1);
    chk(wb_ready == 0, req, 64'(wb_ready), 0);
    chk(rb_valid == 0, req, 64'(rb_valid), 0);
  endtask

  initial begin
    logic [7:0] b, b0;
    logic [63:0] d0, ew;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(dreq_n == 1, "R1 dreq_n", 64'(dreq_n), 1);
    chk(rb_valid == 0 && wb_ready == 0, "R1 byte ports", {rb_valid, wb_ready}, 0);
    chk(sd_rd_req_valid == 0 && sd_wr_valid == 0, "R1 sdram ports",
        {sd_rd_req_valid, sd_wr_valid}, 0);

    // Read mode fill
    load_addr(24'h10);
    exp_rd_addr = 24'h10;
    rd_reqs = 0;
    set_cfg(8'b0000_0010);
    repeat (40) @(negedge clk);
    chk(rd_reqs == 6, "R4 fill limit", 64'(rd_reqs), 6);
    chk(dreq_n == 0, "R6 dreq_n with data", 64'(dreq_n), 0);
    b0 = rb_data;
    repeat (2) @(negedge clk);
    chk(rb_data == b0, "R11 read byte hold", 64'(rb_data), 64'(b0));
    rd_stall = 1;
    @(negedge clk);
    for (int i = 0; i < 48; i++) begin
      chk(dreq_n == 0, "R6 dreq_n while draining", 64'(dreq_n), 0);
      get_byte(b);
      chk(b == rd_byte(24'h10 + 24'(i / 8), i % 8), "R5 read byte", 64'(b),
          64'(rd_byte(24'h10 + 24'(i / 8), i % 8)));
    end
    repeat (2) @(negedge clk);
    chk(dreq_n == 1, "R6 dreq_n empty", 64'(dreq_n), 1);
    chk(rb_valid == 0, "R6 rb_valid empty", 64'(rb_valid), 0);
    rd_stall = 0;
    for (int i = 48; i < 72; i++) begin
      get_byte(b);
      chk(b == rd_byte(24'h10 + 24'(i / 8), i % 8), "R5 R3 read byte after refill", 64'(b),
          64'(rd_byte(24'h10 + 24'(i / 8), i % 8)));
    end

    // Idle and block move
    set_cfg(8'b0000_0000);
    quiet_checks("R2 idle");
    set_cfg(8'b0000_0110);
    quiet_checks("R2 block move");
    set_cfg(8'b0000_0000);
    repeat (3) @(negedge clk);

    // Write mode with reserved bit set
    wr_stall = 1;
    wq_data.delete(); wq_addr.delete();
    load_addr(24'h40);
    set_cfg(8'b0000_0101);
    chk(wb_ready == 1, "R10 reserved bit ignored", 64'(wb_ready), 1);
    chk(dreq_n == 0, "R8 dreq_n empty write fifo", 64'(dreq_n), 0);
    for (int w = 0; w < 8; w++) begin
      for (int k = 0; k < 8; k++) put_byte(wr_byte(w * 8 + k));
      if (w == 4) chk(dreq_n == 0, "R8 dreq_n at 5 words", 64'(dreq_n), 0);
      if (w == 5) chk(dreq_n == 1, "R8 dreq_n at 6 words", 64'(dreq_n), 1);
    end
    chk(wb_ready == 0, "R8 wb_ready full", 64'(wb_ready), 0);
    d0 = sd_wr_data;
    repeat (2) @(negedge clk);
    chk(sd_wr_valid == 1 && sd_wr_data == d0, "R11 write word hold", sd_wr_data, d0);
    wr_stall = 0;
    while (wq_data.size() < 8) @(negedge clk);
    for (int w = 0; w < 8; w++) begin
      for (int k = 0; k < 8; k++) ew[k*8 +: 8] = wr_byte(w * 8 + k);
      chk(wq_data[w] == ew, "R7 packed word", wq_data[w], ew);
      chk(wq_addr[w] == 24'h40 + 24'(w), "R7 write address", 64'(wq_addr[w]), 64'(24'h40 + 24'(w)));
    end

    // Flush on idle
    wr_stall = 1;
    @(negedge clk);
    for (int i = 0; i < 11; i++) put_byte(8'hA0 + 8'(i));
    set_cfg(8'b0000_0000);
    @(negedge clk);
    chk(sd_wr_valid == 0, "R9 write fifo emptied", 64'(sd_wr_valid), 0);
    chk(dreq_n == 1, "R9 dreq_n idle", 64'(dreq_n), 1);
    wq_data.delete(); wq_addr.delete();
    load_addr(24'h80);
    set_cfg(8'b0000_0100);
    wr_stall = 0;
    for (int i = 0; i < 8; i++) put_byte(8'h50 + 8'(i));
    repeat (10) @(negedge clk);
    for (int k = 0; k < 8; k++) ew[k*8 +: 8] = 8'h50 + 8'(k);
    chk(wq_data.size() == 1, "R9 word count after flush", 64'(wq_data.size()), 1);
    if (wq_data.size() > 0) begin
      chk(wq_data[0] == ew, "R9 fresh word", wq_data[0], ew);
      chk(wq_addr[0] == 24'h80, "R9 fresh address", 64'(wq_addr[0]), 64'h80);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule